// File: doc/BRIEF.md
# Two-Dimensional Differential Chain Flag Generator

This block prepares the control words for a joint double-scalar point multiplication that walks a two-dimensional differential addition chain. Given two scalars `k` and `l`, each step of the chain takes three retained points, doubles one of them and forms two sums, one per addition. The block works out for every step which retained point feeds the doubler, which known difference each addition relies on, and which of the two possible mixed-parity points the source level holds. The multiplier then needs no scalar decisions of its own.

A pulse on `start` while idle captures both scalars. After that the block produces one 7-bit flag word per clock, tagged with its step index, for `SCALAR_W` cycles. It then pulses `done`. The retained mixed point at a level depends on the bits below it, so the scan runs from the least significant bit pair upward. The words are meant to be written into a flag memory at their index. The multiplier reads that memory from index `SCALAR_W-1` down to 0. It starts from the zero point, `P+Q` and one of `P` or `Q`, and uses `P+Q` and `P-Q` as precomputed differences.

Top module: `dac2_flag_gen`

## Requirements
- R1: While reset is asserted and after its release with no start, `flag_valid` and `done` are low.
- R2: A `start` seen while idle captures `k_in` and `l_in`. Over the next `SCALAR_W` cycles `flag_valid` is high and `flag_idx` counts 0, 1, … `SCALAR_W-1`, one step per cycle. Index t belongs to bit position t, and bit 0 is the least significant bit.
- R3: `done` is high for exactly one cycle, the cycle right after the word with index `SCALAR_W-1`, and `flag_valid` is low in that cycle.
- R4: `start` is ignored while words are being produced. The index sequence, the words and the timing of `done` are those of the run already in progress.
- R5: The flag word is packed as bit 6 = choice, bits 5:4 = doubling select, bits 3:2 = difference code of the addition that forms the odd/odd point, bits 1:0 = difference code of the addition that forms the mixed point.
- R6: Let pk = k[t] xor k[t+1] and pl = l[t] xor l[t+1], taking bit t+1 as 0 when t = `SCALAR_W-1`. The doubling select is 00 (even/even point) when pk = pl = 0, 01 (odd/odd point) when pk = pl = 1, and 10 (mixed point) otherwise.
- R7: The odd/odd addition code is 00 (difference `P+Q`) when k[t+1] = l[t+1], and 11 (difference `P-Q`) otherwise.
- R8: The mixed-point addition code is 01 (difference `P`) when the choice of level t is 0, and 10 (difference `Q`) when it is 1. Choice 0 means the retained mixed point has an odd `k`-coordinate; choice 1 means it has an odd `l`-coordinate.
- R9: The choice of level 0 is 1 exactly when k[0] = 0 and l[0] = 1, and 0 otherwise. The word for step t carries the choice of level t+1, derived from the choice c of level t as follows: c when (pk,pl) = (0,0); the inverse of c when (1,1); 0 when (1,0); 1 when (0,1).
- R10: Replay the words from index `SCALAR_W-1` down to 0 on integer pairs standing for points, starting from (0,0), (1,1) and (1,0) or (0,1) as given by the top word's choice. Every doubling source is then a retained point, every addition's operands differ by plus or minus its coded difference, and the final three points include (k, l).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; accepted only while idle |
| k_in | input | SCALAR_W | First scalar, sampled on an accepted start |
| l_in | input | SCALAR_W | Second scalar, sampled on an accepted start |
| flag_valid | output | 1 | A flag word is presented this cycle |
| flag_idx | output | IDX_W | Chain step (bit position) of the presented word |
| flag_word | output | 7 | Packed choice, doubling select and two difference codes |
| done | output | 1 | One-cycle pulse after the last word of a run |

## Verification
The cycle that carries the `done` pulse is also the first cycle in which a new `start` is accepted, so the end of one run and the capture of the next can fall on the same clock. The bench provokes this by raising `start` exactly while it observes `done`. It then expects index 0 of the new scalars on the very next cycle, a single `done` for the old run, and a scoreboard that empties in order. A second overlap is a `start` that arrives during a run, with different scalars. Here the scoreboard confirms that the index sequence and every word still follow the scalars captured first. A replay on integer pairs then proves that the chain reaches (k, l).

// File: rtl/dac2_pkg.sv
package dac2_pkg;
  // Known differences between the two operands of an addition.
  typedef enum logic [1:0] {
    DIFF_SUM = 2'b00,   // P+Q
    DIFF_P   = 2'b01,   // P
    DIFF_Q   = 2'b10,   // Q
    DIFF_PMQ = 2'b11    // P-Q
  } diff_code_e;

  // Which retained point feeds the doubler.
  typedef enum logic [1:0] {
    DBL_EVEN = 2'b00,
    DBL_ODD  = 2'b01,
    DBL_MIX  = 2'b10
  } dbl_sel_e;

  typedef struct packed {
    logic       choice;   // mixed-point type of the source level
    dbl_sel_e   dbl;
    diff_code_e add_oo;   // addition that forms the odd/odd point
    diff_code_e add_mix;  // addition that forms the mixed point
  } flag_word_t;

  localparam int FLAG_W = $bits(flag_word_t);
endpackage

// File: rtl/dac2_seq_ctrl.sv
module dac2_seq_ctrl #(
  parameter int SCALAR_W = 16,
  localparam int IDX_W = $clog2(SCALAR_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             accept,
  output logic             busy,
  output logic             last,
  output logic [IDX_W-1:0] step,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SCALAR_W - 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] step_q, step_d;

  assign accept = start & ~busy_q;
  assign last   = busy_q & (step_q == LAST_IDX);

  always_comb begin
    busy_d = busy_q;
    step_d = step_q;
    done_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      step_d = '0;
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        step_d = step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (accept | busy_q) step_q <= step_d;
    end
  end

  assign busy = busy_q;
  assign step = step_q;
  assign done = done_q;

  // R2
  first_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && step == '0));

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && step == $past(step) + 1'b1));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !$past(done)));

  // R4
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && step != '0) |=> (step != '0 || done));
endmodule

// File: rtl/dac2_scalar_shift.sv
module dac2_scalar_shift #(
  parameter int SCALAR_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                adv,
  input  logic [SCALAR_W-1:0] value,
  output logic                bit_lo,
  output logic                bit_hi
);
  logic [SCALAR_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)     sh_d = value;
    else if (adv) sh_d = {1'b0, sh_q[SCALAR_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sh_q <= '0;
    else if (load | adv) sh_q <= sh_d;
  end

  assign bit_lo = sh_q[0];
  assign bit_hi = sh_q[1];
endmodule

// File: rtl/dac2_choice_step.sv
module dac2_choice_step (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic adv,
  input  logic init_k0,
  input  logic init_l0,
  input  logic k_lo,
  input  logic k_hi,
  input  logic l_lo,
  input  logic l_hi,
  output logic par_k,
  output logic par_l,
  output logic c_cur,
  output logic c_next
);
  logic c_q, c_d;

  always_comb begin
    par_k = k_lo ^ k_hi;
    par_l = l_lo ^ l_hi;
    unique case ({par_k, par_l})
      2'b10:   c_next = 1'b0;        // doubling source odd in k only
      2'b01:   c_next = 1'b1;        // doubling source odd in l only
      default: c_next = c_q ^ par_k; // keep on 00, invert on 11
    endcase
  end

  always_comb begin
    c_d = c_q;
    if (load)     c_d = ~init_k0 & init_l0;
    else if (adv) c_d = c_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          c_q <= 1'b0;
    else if (load | adv) c_q <= c_d;
  end

  assign c_cur = c_q;
endmodule

// File: rtl/dac2_flag_pack.sv
module dac2_flag_pack
  import dac2_pkg::*;
(
  input  logic       par_k,
  input  logic       par_l,
  input  logic       k_hi,
  input  logic       l_hi,
  input  logic       c_cur,
  input  logic       c_next,
  output flag_word_t word
);
  always_comb begin
    word.choice = c_next;
    if (par_k == par_l) word.dbl = par_k ? DBL_ODD : DBL_EVEN;
    else                word.dbl = DBL_MIX;
    word.add_oo  = (k_hi == l_hi) ? DIFF_SUM : DIFF_PMQ;
    word.add_mix = c_cur ? DIFF_Q : DIFF_P;
  end
endmodule

// File: rtl/dac2_flag_gen.sv
module dac2_flag_gen
  import dac2_pkg::*;
#(
  parameter int SCALAR_W = 16,
  localparam int IDX_W = $clog2(SCALAR_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SCALAR_W-1:0] k_in,
  input  logic [SCALAR_W-1:0] l_in,
  output logic                flag_valid,
  output logic [IDX_W-1:0]    flag_idx,
  output logic [6:0]          flag_word,
  output logic                done
);
  logic       accept, busy, last;
  logic       k_lo, k_hi, l_lo, l_hi;
  logic       par_k, par_l, c_cur, c_next;
  flag_word_t word_s;

  dac2_seq_ctrl #(.SCALAR_W(SCALAR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .busy(busy), .last(last), .step(flag_idx), .done(done)
  );

  dac2_scalar_shift #(.SCALAR_W(SCALAR_W)) u_k_lane (
    .clk(clk), .rst_n(rst_n), .load(accept), .adv(busy),
    .value(k_in), .bit_lo(k_lo), .bit_hi(k_hi)
  );

  dac2_scalar_shift #(.SCALAR_W(SCALAR_W)) u_l_lane (
    .clk(clk), .rst_n(rst_n), .load(accept), .adv(busy),
    .value(l_in), .bit_lo(l_lo), .bit_hi(l_hi)
  );

  dac2_choice_step u_choice (
    .clk(clk), .rst_n(rst_n), .load(accept), .adv(busy),
    .init_k0(k_in[0]), .init_l0(l_in[0]),
    .k_lo(k_lo), .k_hi(k_hi), .l_lo(l_lo), .l_hi(l_hi),
    .par_k(par_k), .par_l(par_l), .c_cur(c_cur), .c_next(c_next)
  );

  dac2_flag_pack u_pack (
    .par_k(par_k), .par_l(par_l), .k_hi(k_hi), .l_hi(l_hi),
    .c_cur(c_cur), .c_next(c_next), .word(word_s)
  );

  assign flag_valid = busy;
  assign flag_word  = word_s;

  // R3
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !flag_valid);

  // R8 with R9: a step's mixed difference follows the previous word's choice
  choice_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_valid && !last) |=>
      (word_s.add_mix == ($past(word_s.choice) ? DIFF_Q : DIFF_P)));

  // R9: first step uses the level-0 choice taken from the captured low bits
  first_choice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !flag_valid) |=>
      (word_s.add_mix == ((!$past(k_in[0]) && $past(l_in[0])) ? DIFF_Q : DIFF_P)));

  // R6
  dbl_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_valid |-> (flag_word[5:4] != 2'b11));
endmodule

// File: tb/dac2_flag_gen_bench.sv
module dac2_flag_gen_bench;
  localparam int W     = 16;
  localparam int IDX_W = $clog2(W);

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [W-1:0]     k_in, l_in;
  logic             flag_valid;
  logic [IDX_W-1:0] flag_idx;
  logic [6:0]       flag_word;
  logic             done;

  int checks;
  int failures;

  typedef struct {
    int         idx;
    logic [6:0] word;
  } exp_t;

  exp_t       exp_q[$];
  logic [W-1:0] run_k_q[$];
  logic [W-1:0] run_l_q[$];
  logic [6:0] got_words[W];
  bit         pend_done;

  dac2_flag_gen #(.SCALAR_W(W)) u_dac2_flag_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .k_in(k_in), .l_in(l_in),
    .flag_valid(flag_valid), .flag_idx(flag_idx), .flag_word(flag_word),
    .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Expected words from the rules R5..R9, pushed by the driver.
  task automatic push_expected(input logic [W-1:0] k, input logic [W-1:0] l);
    logic c, cn, kl, kh, ll, lh, pk, pl;
    logic [1:0] dsel, d1, d2;
    c = ~k[0] & l[0];                       // R9 level-0 choice
    for (int t = 0; t < W; t++) begin
      kl = k[t]; ll = l[t];
      kh = (t + 1 < W) ? k[t+1] : 1'b0;
      lh = (t + 1 < W) ? l[t+1] : 1'b0;
      pk = kl ^ kh; pl = ll ^ lh;
      if (pk && !pl)      cn = 1'b0;
      else if (!pk && pl) cn = 1'b1;
      else                cn = pk ? ~c : c;
      dsel = (pk == pl) ? {1'b0, pk} : 2'b10;
      d1   = (kh == lh) ? 2'b00 : 2'b11;
      d2   = c ? 2'b10 : 2'b01;
      exp_q.push_back('{idx: t, word: {cn, dsel, d1, d2}});
      c = cn;
    end
  endtask

  task automatic pulse_start(input logic [W-1:0] k, input logic [W-1:0] l);
    push_expected(k, l);
    run_k_q.push_back(k);
    run_l_q.push_back(l);
    k_in  = k;
    l_in  = l;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(input logic [W-1:0] k, input logic [W-1:0] l);
    @(negedge clk);
    while (flag_valid || done) @(negedge clk);
    pulse_start(k, l);
  endtask

  function automatic bit diff_ok(input int dx, input int dy, input logic [1:0] code);
    int vx, vy;
    case (code)
      2'b00:   begin vx = 1; vy = 1;  end
      2'b01:   begin vx = 1; vy = 0;  end
      2'b10:   begin vx = 0; vy = 1;  end
      default: begin vx = 1; vy = -1; end
    endcase
    return (dx == vx && dy == vy) || (dx == -vx && dy == -vy);
  endfunction

  // R10: replay the chain on integer pairs.
  task automatic replay(input logic [W-1:0] k, input logic [W-1:0] l);
    int ea, eb, oa, ob, ma, mb, da, db, xa, xb, pa, pb;
    bit bad;
    logic [6:0] w;
    bad = 0;
    ea = 0; eb = 0; oa = 1; ob = 1;
    if (got_words[W-1][6]) begin ma = 0; mb = 1; end
    else                   begin ma = 1; mb = 0; end
    for (int t = W - 1; t >= 0; t--) begin
      w = got_words[t];
      if (w[6] != ((ma % 2 == 1) ? 1'b0 : 1'b1)) bad = 1;
      case (w[5:4])
        2'b00:   begin da = ea; db = eb; end
        2'b01:   begin da = oa; db = ob; end
        2'b10:   begin da = ma; db = mb; end
        default: begin da = 0; db = 0; bad = 1; end
      endcase
      if (!diff_ok(oa - ea, ob - eb, w[3:2])) bad = 1;
      if (diff_ok(ma - ea, mb - eb, w[1:0]))      begin xa = ea; xb = eb; end
      else if (diff_ok(ma - oa, mb - ob, w[1:0])) begin xa = oa; xb = ob; end
      else begin xa = 0; xb = 0; bad = 1; end
      oa = ea + oa; ob = eb + ob;
      ma = ma + xa; mb = mb + xb;
      ea = 2 * da;  eb = 2 * db;
      pa = int'(k >> t); pb = int'(l >> t);
      if (ea < pa || ea > pa + 1 || eb < pb || eb > pb + 1 || ea % 2 != 0 || eb % 2 != 0) bad = 1;
      if (oa < pa || oa > pa + 1 || ob < pb || ob > pb + 1 || oa % 2 != 1 || ob % 2 != 1) bad = 1;
      if (ma < pa || ma > pa + 1 || mb < pb || mb > pb + 1 || (ma % 2) == (mb % 2)) bad = 1;
    end
    checks++;
    if (bad || !((ea == int'(k) && eb == int'(l)) || (oa == int'(k) && ob == int'(l)) ||
                 (ma == int'(k) && mb == int'(l)))) begin
      failures++;
      $display("FAIL R10 chain replay k=%h l=%h: actual end points (%0d,%0d) (%0d,%0d) (%0d,%0d) consistency=%0d expected (%0d,%0d) reached",
               k, l, ea, eb, oa, ob, ma, mb, !bad, k, l);
    end
  endtask

  // Monitor: pop expected words and compare as they appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_done) begin
        checks++;
        if (!(done && !flag_valid)) begin
          failures++;
          $display("FAIL R3 done after last word: actual done=%b valid=%b expected done=1 valid=0",
                   done, flag_valid);
        end
        pend_done = 0;
        if (done && run_k_q.size() > 0) replay(run_k_q.pop_front(), run_l_q.pop_front());
      end else if (done) begin
        checks++; failures++;
        $display("FAIL R3 stray done: actual done=1 expected done=0");
      end
      if (flag_valid) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R2 unexpected word idx=%0d: actual valid=1 expected valid=0", flag_idx);
        end else begin
          e = exp_q.pop_front();
          checks++;
          if (int'(flag_idx) != e.idx) begin
            failures++;
            $display("FAIL R2 R4 index: actual %0d expected %0d", flag_idx, e.idx);
          end
          checks++;
          if (flag_word[6] != e.word[6]) begin
            failures++;
            $display("FAIL R9 choice idx=%0d: actual %b expected %b", e.idx, flag_word[6], e.word[6]);
          end
          checks++;
          if (flag_word[5:4] != e.word[5:4]) begin
            failures++;
            $display("FAIL R6 doubling select idx=%0d: actual %b expected %b", e.idx, flag_word[5:4], e.word[5:4]);
          end
          checks++;
          if (flag_word[3:2] != e.word[3:2]) begin
            failures++;
            $display("FAIL R7 odd/odd code idx=%0d: actual %b expected %b", e.idx, flag_word[3:2], e.word[3:2]);
          end
          checks++;
          if (flag_word[1:0] != e.word[1:0]) begin
            failures++;
            $display("FAIL R8 mixed code idx=%0d: actual %b expected %b", e.idx, flag_word[1:0], e.word[1:0]);
          end
          got_words[flag_idx] = flag_word;  // R5 layout used by the replay
          if (int'(flag_idx) == W - 1) pend_done = 1;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: actual run still active expected finished");
    finish_run();
  end

  initial begin
    logic [W-1:0] lf;
    checks = 0; failures = 0; pend_done = 0;
    rst_n = 1'b0; start = 1'b0; k_in = '0; l_in = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (flag_valid || done) begin
      failures++;
      $display("FAIL R1 in reset: actual valid=%b done=%b expected 0 0", flag_valid, done);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (flag_valid || done) begin
      failures++;
      $display("FAIL R1 idle after reset: actual valid=%b done=%b expected 0 0", flag_valid, done);
    end

    // Corner patterns (R2, R6..R10)
    run_case(16'h0000, 16'h0000);
    run_case(16'h0001, 16'h0000);
    run_case(16'h0000, 16'h0001);
    run_case(16'hFFFF, 16'h0000);
    run_case(16'h0000, 16'hFFFF);
    run_case(16'hFFFF, 16'hFFFF);
    run_case(16'hAAAA, 16'h5555);
    run_case(16'h8000, 16'h8000);
    run_case(16'h1234, 16'hABCD);
    run_case(16'hC3A5, 16'h0F0F);

    // R4: start during a run with other scalars must be ignored
    run_case(16'h5A5A, 16'h3C3C);
    repeat (4) @(negedge clk);
    k_in = 16'hFFFF; l_in = 16'h0001; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!(flag_valid && int'(flag_idx) == W - 1)) @(negedge clk);
    k_in = 16'h7777; l_in = 16'h1111; start = 1'b1;   // coincides with last step
    @(negedge clk);
    start = 1'b0;

    // Back-to-back: new start raised in the done cycle (R2, R3)
    run_case(16'h0F0F, 16'hF0F0);
    while (!done) @(negedge clk);
    pulse_start(16'h9E37, 16'h79B9);

    // Pseudo-random pairs from a fixed LFSR
    lf = 16'hACE1;
    for (int n = 0; n < 20; n++) begin
      logic [W-1:0] a, b;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      b = lf ^ {lf[7:0], lf[15:8]};
      run_case(a, b);
    end

    @(negedge clk);
    while (flag_valid || done || pend_done) @(negedge clk);
    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R2 words missing: actual %0d left expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule